// File: doc/BRIEF.md
# Deep Sleep Wake-Up Controller

This block sits in the always-on power domain. It moves the chip into a deep sleep state and brings it back out. Software programs a control register and then issues a separate sleep command pulse. The controller then freezes the pad drive at its current values and waits for a wake condition.

Five wake inputs are watched:
- a supply reset event
- a watchdog expiry
- a real-time clock alarm, which counts only while its enable bit is set
- a low level on the active-low external reset pin
- a transition of the interrupt pin to a programmable active level, which counts only if its enable bit was set before entry

On wake, the controller records every source that fired in that cycle. It then holds the core in reset for a parameterised number of cycles, plus an extra stretch when the core supply capacitor is reported low. After that it lets the core run again.

Two general-purpose registers, the wake-source bits, a brown-out flag and the pad hold keep their contents across this reset. The hold ends only when software clears the release bit. All registers sit on a small word-addressed bus. Reads are combinational. Writes take effect only while the core is running.

Top module: `dsleep_wake_ctrl`

## Requirements
- R1: Sleep is entered on the clock edge where the sleep command pulse arrives while the enable bit (address 0, bit 0) is set and the core is running. `asleep` is high from the next cycle. A sleep command with the enable bit clear has no effect.
- R2: While asleep, each wake source that fires sets its own bit in the wake register (address 2) and ends sleep: bit 0 supply event, bit 1 watchdog, bit 2 clock alarm, bit 3 external reset low. The clock alarm counts only when address 0 bit 1 is set. Sources that fire in the same cycle all set their bits.
- R3: The interrupt pin wakes the block (wake bit 4) only when address 0 bit 2 is set. It also needs a change of the pin to the level selected by address 0 bit 3 (1 = high) while asleep. A pin already at that level at entry does not wake, and neither does a change to the other level.
- R4: The pending-interrupt flag (address 0 bit 4) sets when the enabled pin changes to its active level while running. Writing 1 to it clears it. It is cleared on the entry edge.
- R5: After a wake, `core_rst_n` stays low for RST_CYC cycles, or RST_CYC+CAP_CYC cycles if `vcap_low` is high in the wake cycle. Wake sources in this window are not recorded.
- R6: A wake sets the exit flag (address 3 bit 0). It stays set until software writes 1 to that bit.
- R7: A wake clears every bit of address 0. The retention registers at addresses 4 and 5 keep their values. All registers read 0 after the always-on reset.
- R8: A brown-out pulse while asleep sets address 1 bit 1. The flag survives the wake and is cleared by writing 1 to it.
- R9: Entry sets the release bit (address 1 bit 0) and freezes `pad_oe` as the inverted direction bits and `pad_out` as the latch bits. The frozen values hold until a write with bit 0 = 0 clears the release bit. Writing 1 to bit 0 does not change it.
- R10: Wake register bits are cleared by writing 1 to them.
- R11: Bus writes are ignored while asleep or in the reset window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on domain reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| sleep_cmd | input | 1 | Sleep command pulse |
| sup_evt | input | 1 | Supply reset event pulse |
| wdt_tmo | input | 1 | Watchdog expiry pulse |
| rtc_alarm | input | 1 | Clock alarm pulse |
| ext_rst_n | input | 1 | External reset pin, active low |
| int_pin | input | 1 | External interrupt pin |
| bor_evt | input | 1 | Brown-out pulse |
| vcap_low | input | 1 | Core capacitor low status |
| core_tris | input | N_PINS | Core pin directions (1 = input) |
| core_lat | input | N_PINS | Core output latch values |
| pad_oe | output | N_PINS | Pad output enables |
| pad_out | output | N_PINS | Pad output values |
| asleep | output | 1 | High while in deep sleep |
| core_rst_n | output | 1 | Core reset, low while asleep or in the reset window |
| pin_hold | output | 1 | Release bit, high while pads are frozen |

## Verification
The assertions watch, on every cycle:
- that entry only follows a command with the enable bit set;
- that the pads stay frozen while asleep;
- that the pending flag is clear on entry;
- that the exit flag and the cleared enable bit appear on wake;
- that the wake register holds still through the reset window;
- that the window always has one of the two legal lengths.

Only the bench's scenarios can show the rest:
- which bit each source sets, including simultaneous sources;
- that a disabled clock alarm and a non-armed or already-asserted interrupt pin do not wake;
- that the wrong polarity does not wake;
- that the retention and brown-out state survives while bus writes during sleep are dropped.

// File: rtl/dsleep_wake_ctrl.sv
module dsleep_wake_ctrl #(
  parameter int DW      = 16,
  parameter int N_PINS  = 8,
  parameter int RST_CYC = 16,
  parameter int CAP_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              sleep_cmd,
  input  logic              sup_evt,
  input  logic              wdt_tmo,
  input  logic              rtc_alarm,
  input  logic              ext_rst_n,
  input  logic              int_pin,
  input  logic              bor_evt,
  input  logic              vcap_low,
  input  logic [N_PINS-1:0] core_tris,
  input  logic [N_PINS-1:0] core_lat,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic              asleep,
  output logic              core_rst_n,
  output logic              pin_hold
);
  localparam int CW = $clog2(RST_CYC + CAP_CYC + 1);

  typedef enum logic [1:0] {RUN, SLEEP, WAIT} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic            slp_en, rtc_en, int_en, int_pol, int_flag;
  logic            pin_q, release_q, bor_q, exit_q;
  logic [4:0]      wake_src;
  logic [DW-1:0]   gpr0, gpr1;
  logic [N_PINS-1:0] hold_oe, hold_out;

  logic       pin_edge, enter, wake_any, wr;
  logic [4:0] wake_hit;

  assign pin_edge = (int_pin == int_pol) && (pin_q != int_pol);
  assign wake_hit = {int_en && pin_edge, !ext_rst_n, rtc_alarm && rtc_en, wdt_tmo, sup_evt};
  assign enter    = (st == RUN) && slp_en && sleep_cmd;
  assign wake_any = (st == SLEEP) && (|wake_hit);
  assign wr       = bus_we && (st == RUN) && !enter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RUN;
      cnt   <= '0;
      pin_q <= 1'b0;
    end else begin
      pin_q <= int_pin;
      case (st)
        RUN:   if (enter) st <= SLEEP;
        SLEEP: if (wake_any) begin
                 st  <= WAIT;
                 cnt <= vcap_low ? CW'(RST_CYC + CAP_CYC - 1) : CW'(RST_CYC - 1);
               end
        default: begin
                 if (cnt == '0) st <= RUN;
                 else           cnt <= cnt - 1'b1;
               end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {slp_en, rtc_en, int_en, int_pol, int_flag} <= '0;
    end else if (wake_any) begin
      {slp_en, rtc_en, int_en, int_pol, int_flag} <= '0;
    end else if (enter) begin
      int_flag <= 1'b0;
    end else if (st == RUN) begin
      if (wr && bus_addr == 3'd0) begin
        slp_en  <= bus_wdata[0];
        rtc_en  <= bus_wdata[1];
        int_en  <= bus_wdata[2];
        int_pol <= bus_wdata[3];
      end
      int_flag <= (int_flag && !(wr && bus_addr == 3'd0 && bus_wdata[4])) || (int_en && pin_edge);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      bor_q     <= 1'b0;
      exit_q    <= 1'b0;
      wake_src  <= '0;
      gpr0      <= '0;
      gpr1      <= '0;
      hold_oe   <= '0;
      hold_out  <= '0;
    end else begin
      if (enter) begin
        release_q <= 1'b1;
        hold_oe   <= ~core_tris;
        hold_out  <= core_lat;
      end
      if (st == SLEEP && bor_evt) bor_q <= 1'b1;
      if (wake_any) begin
        wake_src <= wake_src | wake_hit;
        exit_q   <= 1'b1;
      end
      if (wr) begin
        case (bus_addr)
          3'd1: begin
            if (!bus_wdata[0]) release_q <= 1'b0;
            if (bus_wdata[1])  bor_q     <= 1'b0;
          end
          3'd2: wake_src <= wake_src & ~bus_wdata[4:0];
          3'd3: if (bus_wdata[0]) exit_q <= 1'b0;
          3'd4: gpr0 <= bus_wdata;
          3'd5: gpr1 <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: bus_rdata[4:0] = {int_flag, int_pol, int_en, rtc_en, slp_en};
      3'd1: bus_rdata[1:0] = {bor_q, release_q};
      3'd2: bus_rdata[4:0] = wake_src;
      3'd3: bus_rdata[0]   = exit_q;
      3'd4: bus_rdata      = gpr0;
      3'd5: bus_rdata      = gpr1;
      default: ;
    endcase
  end

  assign asleep     = (st == SLEEP);
  assign core_rst_n = (st == RUN);
  assign pin_hold   = release_q;
  assign pad_oe     = release_q ? hold_oe  : ~core_tris;
  assign pad_out    = release_q ? hold_out : core_lat;
endmodule

// File: rtl/dsleep_wake_chk.sv
module dsleep_wake_chk #(
  parameter int N_PINS  = 8,
  parameter int RST_CYC = 16,
  parameter int CAP_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              asleep,
  input logic              in_wait,
  input logic              sleep_cmd,
  input logic              slp_en,
  input logic              int_flag,
  input logic              exit_q,
  input logic              pin_hold,
  input logic [4:0]        wake_src,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] pad_out
);
  int wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= 0;
    else        wcnt <= in_wait ? wcnt + 1 : 0;
  end

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n) $rose(asleep) |-> $past(slp_en && sleep_cmd)); // R1
  AST_INT_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) $rose(asleep) |-> !int_flag); // R4
  AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(in_wait) |-> (wcnt == RST_CYC || wcnt == RST_CYC + CAP_CYC)); // R5
  AST_SRC_FROZEN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) in_wait && $past(in_wait) |-> $stable(wake_src)); // R5
  AST_EXIT_FLAG_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n) $fell(asleep) |-> exit_q); // R6
  AST_ENABLE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) $fell(asleep) |-> !slp_en); // R7
  AST_HOLD_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n) asleep |-> pin_hold); // R9
  AST_PADS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) asleep && $past(asleep) |-> $stable(pad_oe) && $stable(pad_out)); // R9
endmodule

bind dsleep_wake_ctrl dsleep_wake_chk #(
  .N_PINS(N_PINS), .RST_CYC(RST_CYC), .CAP_CYC(CAP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .asleep(asleep), .in_wait(!asleep && !core_rst_n),
  .sleep_cmd(sleep_cmd), .slp_en(slp_en), .int_flag(int_flag), .exit_q(exit_q),
  .pin_hold(pin_hold), .wake_src(wake_src), .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/dsleep_wake_ctrl_bench.sv
module dsleep_wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, NP = 8, RC = 16, CC = 8;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic sleep_cmd = 0, sup_evt = 0, wdt_tmo = 0, rtc_alarm = 0, ext_rst_n = 1;
  logic int_pin = 0, bor_evt = 0, vcap_low = 0;
  logic [NP-1:0] core_tris = 8'hF0, core_lat = 8'h5A, pad_oe, pad_out;
  logic asleep, core_rst_n, pin_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsleep_wake_ctrl #(.DW(DW), .N_PINS(NP), .RST_CYC(RC), .CAP_CYC(CC)) u_dsleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sleep_cmd(sleep_cmd), .sup_evt(sup_evt), .wdt_tmo(wdt_tmo),
    .rtc_alarm(rtc_alarm), .ext_rst_n(ext_rst_n), .int_pin(int_pin), .bor_evt(bor_evt),
    .vcap_low(vcap_low), .core_tris(core_tris), .core_lat(core_lat), .pad_oe(pad_oe),
    .pad_out(pad_out), .asleep(asleep), .core_rst_n(core_rst_n), .pin_hold(pin_hold));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 = running, 1 = asleep, 2 = reset window
  int m_st = 0, m_left = 0;
  bit m_slp, m_rtc, m_ien, m_pol, m_flag, m_pin, m_rel, m_bor, m_exit;
  bit [4:0] m_src;
  bit [DW-1:0] m_g0, m_g1;
  bit [NP-1:0] m_hoe, m_hout;

  function automatic logic [DW-1:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return DW'({m_flag, m_pol, m_ien, m_rtc, m_slp});
      3'd1: return DW'({m_bor, m_rel});
      3'd2: return DW'(m_src);
      3'd3: return DW'(m_exit);
      3'd4: return m_g0;
      3'd5: return m_g1;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0;
      {m_slp, m_rtc, m_ien, m_pol, m_flag, m_pin, m_rel, m_bor, m_exit} = '0;
      m_src = 0; m_g0 = 0; m_g1 = 0; m_hoe = 0; m_hout = 0;
    end else begin
      bit edge_hit;
      bit [4:0] hit;
      edge_hit = (int_pin == m_pol) && (m_pin != m_pol);
      hit = 0;
      if (sup_evt) hit[0] = 1;
      if (wdt_tmo) hit[1] = 1;
      if (rtc_alarm && m_rtc) hit[2] = 1;
      if (!ext_rst_n) hit[3] = 1;
      if (m_ien && edge_hit) hit[4] = 1;
      if (m_st == 0) begin
        if (m_slp && sleep_cmd) begin
          m_st = 1; m_rel = 1; m_hoe = ~core_tris; m_hout = core_lat; m_flag = 0;
        end else begin
          bit set_flag;
          set_flag = m_ien && edge_hit;
          if (bus_we) begin
            if (bus_addr == 0) begin
              m_slp = bus_wdata[0]; m_rtc = bus_wdata[1]; m_ien = bus_wdata[2]; m_pol = bus_wdata[3];
              if (bus_wdata[4]) m_flag = 0;
            end else if (bus_addr == 1) begin
              if (!bus_wdata[0]) m_rel = 0;
              if (bus_wdata[1]) m_bor = 0;
            end else if (bus_addr == 2) m_src = m_src & ~bus_wdata[4:0];
            else if (bus_addr == 3) begin
              if (bus_wdata[0]) m_exit = 0;
            end else if (bus_addr == 4) m_g0 = bus_wdata;
            else if (bus_addr == 5) m_g1 = bus_wdata;
          end
          if (set_flag) m_flag = 1;
        end
      end else if (m_st == 1) begin
        if (bor_evt) m_bor = 1;
        if (hit != 0) begin
          m_src = m_src | hit; m_exit = 1;
          {m_slp, m_rtc, m_ien, m_pol, m_flag} = '0;
          m_left = vcap_low ? RC + CC : RC;
          m_st = 2;
        end
      end else begin
        m_left--;
        if (m_left == 0) m_st = 0;
      end
      m_pin = int_pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(asleep == (m_st == 1), "R1 asleep vs model", asleep, m_st == 1);
      chk(core_rst_n == (m_st == 0), "R5 core_rst_n vs model", core_rst_n, m_st == 0);
      chk(pin_hold == m_rel, "R9 pin_hold vs model", pin_hold, m_rel);
      chk(pad_oe == (m_rel ? m_hoe : ~core_tris), "R9 pad_oe vs model", pad_oe, m_rel ? m_hoe : ~core_tris);
      chk(pad_out == (m_rel ? m_hout : core_lat), "R9 pad_out vs model", pad_out, m_rel ? m_hout : core_lat);
      chk(bus_rdata == m_read(bus_addr), "R2 R7 bus_rdata vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1; tick(); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    bus_addr = a; @(negedge clk); chk(bus_rdata == e, tag, bus_rdata, e); tick();
  endtask

  task automatic sleep_now();
    sleep_cmd = 1; tick(); sleep_cmd = 0;
  endtask

  task automatic window(input bit noise, output int n);
    n = 0;
    wdt_tmo = noise;
    forever begin
      @(negedge clk);
      if (core_rst_n || n > 1000) break;
      n++;
      @(posedge clk); #1;
    end
    wdt_tmo = 0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1; tick();
    for (int a = 0; a < 6; a++) rd(3'(a), 0, "R7 reset value");

    wr(4, 16'hBEEF); wr(5, 16'h1234);
    wr(0, 16'h000E);
    int_pin = 1; tick();
    rd(0, 16'h001E, "R4 pending flag set on active edge");
    sleep_now(); tick();
    chk(asleep == 0, "R1 command ignored without enable", asleep, 0);
    wr(0, 16'h000F);
    rd(0, 16'h001F, "R4 writing 0 keeps flag");
    sleep_now();
    @(negedge clk); chk(asleep == 1, "R1 asleep after command", asleep, 1); tick();
    rd(0, 16'h000F, "R4 flag cleared at entry");
    core_lat = 8'hFF; core_tris = 8'h00;
    repeat (3) tick();
    chk(asleep == 1, "R3 pin already asserted no wake", asleep, 1);
    @(negedge clk);
    chk(pad_oe == 8'h0F && pad_out == 8'h5A, "R9 pads frozen", {pad_oe, pad_out}, 16'h0F5A);
    tick();
    wr(4, 16'h0000);
    rtc_alarm = 1; tick(); rtc_alarm = 0;
    window(1, n);
    chk(n == RC, "R5 window length", n, RC);
    rd(2, 16'h0004, "R2 alarm bit only, window events dropped");
    rd(3, 16'h0001, "R6 exit flag set");
    rd(0, 16'h0000, "R7 control cleared on wake");
    rd(4, 16'hBEEF, "R11 sleep write dropped, R7 retained");
    rd(5, 16'h1234, "R7 second retention kept");
    wr(1, 16'h0001);
    @(negedge clk); chk(pin_hold == 1, "R9 writing 1 keeps hold", pin_hold, 1); tick();
    wr(1, 16'h0000);
    @(negedge clk); chk(pad_oe == 8'hFF && pad_out == 8'hFF, "R9 released pads follow core", {pad_oe, pad_out}, 16'hFFFF); tick();
    wr(2, 16'h0004); rd(2, 0, "R10 wake bit cleared by write 1");
    wr(3, 16'h0001); rd(3, 0, "R6 exit flag cleared");

    wr(0, 16'h0001); sleep_now();
    rtc_alarm = 1; tick(); rtc_alarm = 0; tick();
    chk(asleep == 1, "R2 disabled alarm no wake", asleep, 1);
    vcap_low = 1; sup_evt = 1; wdt_tmo = 1; tick(); sup_evt = 0; wdt_tmo = 0; vcap_low = 0;
    window(0, n);
    chk(n == RC + CC, "R5 extended window with low capacitor", n, RC + CC);
    rd(2, 16'h0003, "R2 simultaneous sources");
    wr(2, 16'h0001); rd(2, 16'h0002, "R10 per-bit clear");
    wr(2, 16'h0002); wr(1, 16'h0000);

    int_pin = 0; wr(0, 16'h0005); tick();
    sleep_now(); repeat (3) tick();
    chk(asleep == 1, "R3 low level at entry no wake", asleep, 1);
    int_pin = 1; repeat (2) tick();
    chk(asleep == 1, "R3 wrong polarity no wake", asleep, 1);
    int_pin = 0; tick();
    window(0, n);
    rd(2, 16'h0010, "R3 pin wake recorded");
    wr(2, 16'h0010); wr(1, 16'h0000);

    wr(0, 16'h0001); sleep_now();
    int_pin = 1; tick(); int_pin = 0; tick(); int_pin = 1; tick();
    chk(asleep == 1, "R3 pin not armed no wake", asleep, 1);
    bor_evt = 1; tick(); bor_evt = 0; tick();
    chk(asleep == 1, "R8 brown-out is not a wake", asleep, 1);
    ext_rst_n = 0; tick(); ext_rst_n = 1;
    window(0, n);
    rd(2, 16'h0008, "R2 external reset bit");
    rd(1, 16'h0003, "R8 brown-out flag retained");
    wr(1, 16'h0002);
    rd(1, 16'h0000, "R8 R9 flag and hold cleared");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule